// File: doc/BRIEF.md
# Wired-AND Shared-Line Access Arbiter

This block is the arbitration logic of one node on a shared open-drain upstream line. As many as eight devices sit on that line: this node plus up to seven others. Their outputs combine as a wired-AND, and pull-ups make any bit that nobody drives read as 1. The devices compete for the common layer-1 resources and the D channel. Contention is settled once per TDM frame, inside a single octet slot: the last octet of channel 2. The node first reads a bus-accessed bit. It then sends its 3-bit address one bit at a time and compares each bit with the value it reads back from the line. The device that gets through its whole address without a mismatch holds the line. The lowest address therefore wins.

A request comes from a software request pin or from an HDLC-transmit request pin. The two are ORed. While the request stays high, the winner marks the line as occupied in every later frame by pulling the bus-accessed bit low. A node that lost stays released. It tries again in the next frame that shows the line free. The line is driven only while the enable pin is high. All interfaces are plain control pins. Nothing in the block carries a data stream, so no valid/ready handshake or back-pressure applies.

Top module: `wand_bus_arbiter`

## Requirements
- R1: The octet slot occupies frame bits SLOT_POS to SLOT_POS+7. Frame bit 0 is the bit in which `fsync` is high. Octet bit b falls in frame bit SLOT_POS+7-b. `drive_low` is asserted only at octet bit 5 (bus-accessed) and octet bits 2..0 (address). Octet bits 7, 6, 4 and 3, and every bit outside the slot, stay released.
- R2: The node has a pending request when `sw_req` or `tx_req` is 1. Either source alone starts an attempt in the same way.
- R3: A node with a pending request that is not already granted starts an attempt only if octet bit 5 reads 1 (free). If it reads 0 (occupied), the node drives no address bit in that frame and neither `granted` nor `lost` is set.
- R4: During an attempt, address bit i is sent in octet bit i, which puts the MSB first. `drive_low` is 1 for an address bit of 0 and 0 for an address bit of 1.
- R5: If the node releases a bit (sends 1) and reads back 0, it withdraws. It drives no further bit in that frame, and `lost` is 1 from the cycle after that bit.
- R6: A node that sends all address bits without a mismatch has `granted` set in the cycle after octet bit 0. Among simultaneous requesters the lowest address wins.
- R7: While granted and its request is held, the node drives octet bit 5 low in every later frame and drives no address bit.
- R8: One cycle after the request drops, `granted` and `lost` are both 0.
- R9: A node whose `lost` is 1 keeps `lost` through busy frames. It retries in the next frame whose octet bit 5 reads 1 while its request is still pending.
- R10: While `arb_en` is 0, `drive_low` stays 0 and no grant is taken.
- R11: After reset, `drive_low`, `granted` and `lost` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | High during frame bit 0 |
| line_in | input | 1 | Line value sampled in the current bit |
| sw_req | input | 1 | Software access request |
| tx_req | input | 1 | HDLC-transmit access request |
| node_addr | input | 3 | Programmed node address |
| arb_en | input | 1 | Arbitration enable (mode selected) |
| drive_low | output | 1 | 1 pulls the open-drain line to 0 |
| granted | output | 1 | Node holds the line |
| lost | output | 1 | Node lost its last attempt |

## Verification
The assertions take for granted three properties of the inputs. `line_in` is the wired-AND of this node's `drive_low` with the other devices' drives in the same bit. `fsync` recurs every FRAME_BITS cycles. The request pins and `node_addr` change only away from the slot. The bench keeps within these assumptions. It builds `line_in` from the node's live drive combined with a modelled rival that itself arbitrates by the same rules. It issues `fsync` exactly once per frame, and it changes requests and addresses only between frames.

// File: rtl/wab_pkg.sv
`timescale 1ns/1ps
package wab_pkg;
  localparam int OCT_BITS = 8;
  typedef logic [2:0] slot_idx_t;
endpackage

// File: rtl/wab_framer.sv
`timescale 1ns/1ps
module wab_framer
  import wab_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int SLOT_POS   = 24
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fsync,
  output logic      in_slot,
  output slot_idx_t k
);
  localparam int POS_W = $clog2(FRAME_BITS);

  logic [POS_W-1:0] cnt_q;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] off;
  logic             synced_q;

  always_comb begin
    pos     = fsync ? '0 : cnt_q;
    off     = pos - POS_W'(SLOT_POS);
    in_slot = (fsync | synced_q) && (pos >= POS_W'(SLOT_POS)) && (off < POS_W'(OCT_BITS));
    k       = off[2:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      synced_q <= synced_q | fsync;
      cnt_q    <= (pos == POS_W'(FRAME_BITS - 1)) ? '0 : pos + 1'b1;
    end
  end
endmodule

// File: rtl/wab_core.sv
`timescale 1ns/1ps
module wab_core
  import wab_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int BAC_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              req,
  input  logic              line_in,
  input  logic              in_slot,
  input  slot_idx_t         k,
  input  logic [ADDR_W-1:0] node_addr,
  output logic              drive_low,
  output logic              granted,
  output logic              lost
);
  localparam slot_idx_t BAC_K   = slot_idx_t'(OCT_BITS - 1 - BAC_BIT);
  localparam slot_idx_t ADDR_K0 = slot_idx_t'(OCT_BITS - ADDR_W);
  localparam slot_idx_t LAST_K  = slot_idx_t'(OCT_BITS - 1);

  logic                try_q, granted_q, lost_q;
  logic                bac_slot, addr_slot, last_slot;
  logic [OCT_BITS-1:0] addr_oct;
  logic                cur_bit, go, clash;

  always_comb begin
    go        = en & req;
    bac_slot  = in_slot && (k == BAC_K);
    addr_slot = in_slot && (k >= ADDR_K0);
    last_slot = in_slot && (k == LAST_K);
    addr_oct  = OCT_BITS'(node_addr);
    cur_bit   = addr_oct[LAST_K - k];
    drive_low = go & ((bac_slot & granted_q) | (addr_slot & try_q & ~cur_bit));
    clash     = try_q & addr_slot & cur_bit & ~line_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !go) begin
      try_q     <= 1'b0;
      granted_q <= 1'b0;
      lost_q    <= 1'b0;
    end else if (bac_slot && !granted_q && line_in) begin
      try_q  <= 1'b1;
      lost_q <= 1'b0;
    end else if (clash) begin
      try_q  <= 1'b0;
      lost_q <= 1'b1;
    end else if (last_slot && try_q) begin
      try_q     <= 1'b0;
      granted_q <= 1'b1;
    end
  end

  assign granted = granted_q;
  assign lost    = lost_q;

  a_r1_drive_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> (bac_slot || addr_slot));
  a_r5_quiet_after_clash: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> !(drive_low && addr_slot));
  a_r5_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(granted_q && lost_q));
  a_r6_grant_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted_q) |-> $past(last_slot));
  a_r7_owner_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (granted_q && addr_slot) |-> !drive_low);
  a_r8_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!granted_q && !lost_q));
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !drive_low);
endmodule

// File: rtl/wand_bus_arbiter.sv
`timescale 1ns/1ps
module wand_bus_arbiter
  import wab_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int SLOT_POS   = 24,
  parameter int ADDR_W     = 3,
  parameter int BAC_BIT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              line_in,
  input  logic              sw_req,
  input  logic              tx_req,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              arb_en,
  output logic              drive_low,
  output logic              granted,
  output logic              lost
);
  logic      in_slot;
  slot_idx_t k;
  logic      req_any;

  assign req_any = sw_req | tx_req;

  wab_framer #(.FRAME_BITS(FRAME_BITS), .SLOT_POS(SLOT_POS)) u_framer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .in_slot(in_slot), .k(k)
  );

  wab_core #(.ADDR_W(ADDR_W), .BAC_BIT(BAC_BIT)) u_core (
    .clk(clk), .rst_n(rst_n), .en(arb_en), .req(req_any), .line_in(line_in),
    .in_slot(in_slot), .k(k), .node_addr(node_addr),
    .drive_low(drive_low), .granted(granted), .lost(lost)
  );

  a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> $past(req_any));
  a_r3_lost_only_from_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> $past(in_slot && (k >= 3'd5)));
endmodule

// File: tb/sim_wand_bus_arbiter.sv
`timescale 1ns/1ps
module sim_wand_bus_arbiter;
  localparam int FRAME = 32;
  localparam int SLOT  = 24;
  // vector: [10:8] node addr, [7] rival on, [6:4] rival addr, [3] busy, [2] exp granted, [1] exp lost
  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    {3'd3, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd3, 1'b1, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd5, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd0, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd7, 1'b1, 3'd6, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd6, 1'b1, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd2, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd4, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic sw_req = 1'b0;
  logic tx_req = 1'b0;
  logic arb_en = 1'b1;
  logic [2:0] daddr = 3'd0;
  logic other_low = 1'b0;
  logic line_in, drive_low, granted, lost;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int bad_pos, after_loss;
  logic bac_drv;
  logic [2:0] drv_addr;

  always #2.5 clk = ~clk;

  assign line_in = ~(drive_low | other_low);

  wand_bus_arbiter #(.FRAME_BITS(FRAME), .SLOT_POS(SLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .line_in(line_in),
    .sw_req(sw_req), .tx_req(tx_req), .node_addr(daddr), .arb_en(arb_en),
    .drive_low(drive_low), .granted(granted), .lost(lost)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic r_en, input logic [2:0] raddr, input logic busy);
    logic r_in;
    logic lost_seen;
    r_in = 1'b0; lost_seen = 1'b0;
    bad_pos = 0; after_loss = 0; bac_drv = 1'b0; drv_addr = 3'b000;
    for (int p = 0; p < FRAME; p++) begin
      int ob;
      bit slot;
      @(negedge clk);
      fsync = (p == 0);
      slot = (p >= SLOT) && (p < SLOT + 8);
      ob = 7 - (p - SLOT);
      other_low = 1'b0;
      if (slot && ob == 5) other_low = busy;
      else if (slot && ob < 3 && r_in) other_low = ~raddr[ob];
      #1;
      if (drive_low) begin
        if (slot && ob == 5) bac_drv = 1'b1;
        else if (slot && ob < 3) begin
          drv_addr[ob] = 1'b1;
          if (lost_seen) after_loss++;
        end else bad_pos++;
      end
      if (slot && ob == 5 && r_en && line_in) r_in = 1'b1;
      if (slot && ob < 3) begin
        if (r_in && raddr[ob] && !line_in) r_in = 1'b0;
        if (!drive_low && daddr[ob] && !line_in) lost_seen = 1'b1;
      end
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(drive_low == 1'b0, "R11 drive in reset", int'(drive_low), 0);
    chk(granted == 1'b0, "R11 granted in reset", int'(granted), 0);
    chk(lost == 1'b0, "R11 lost in reset", int'(lost), 0);
    rst_n = 1'b1;
    run_frame(1'b0, 3'd0, 1'b0);
    chk(granted == 1'b0 && lost == 1'b0, "R11 idle after reset", int'({granted, lost}), 0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      daddr = v[10:8];
      sw_req = (i % 2 == 0);
      tx_req = (i % 2 == 1);
      run_frame(v[7], v[6:4], v[3]);
      chk(granted == v[2], "R6/R2 granted", int'(granted), int'(v[2]));
      chk(lost == v[1], "R5 lost", int'(lost), int'(v[1]));
      chk(bad_pos == 0, "R1 drive at released bit", bad_pos, 0);
      chk(bac_drv == 1'b0, "R7 busy bit driven by non-owner", int'(bac_drv), 0);
      if (v[2]) chk(drv_addr == ~v[10:8], "R4 address drive pattern", int'(drv_addr), int'(~v[10:8]));
      if (v[1]) chk(after_loss == 0, "R5 drive after withdraw", after_loss, 0);
      if (v[3]) chk(drv_addr == 3'b000, "R3 address sent on busy line", int'(drv_addr), 0);
      sw_req = 1'b0; tx_req = 1'b0;
      run_frame(1'b0, 3'd0, 1'b0);
      chk(granted == 1'b0 && lost == 1'b0, "R8 flags after drop", int'({granted, lost}), 0);
    end

    // R7: owner holds, marks line occupied, rival with lower address stays out
    daddr = 3'd2; sw_req = 1'b1;
    run_frame(1'b0, 3'd0, 1'b0);
    chk(granted == 1'b1, "R6 win alone", int'(granted), 1);
    run_frame(1'b1, 3'd0, 1'b0);
    chk(bac_drv == 1'b1, "R7 owner drives busy bit", int'(bac_drv), 1);
    chk(drv_addr == 3'b000, "R7 owner sends no address", int'(drv_addr), 0);
    chk(granted == 1'b1, "R7 grant kept", int'(granted), 1);
    // R8: one cycle after drop
    sw_req = 1'b0;
    @(posedge clk); #1;
    chk(granted == 1'b0, "R8 grant one cycle after drop", int'(granted), 0);

    // R9: lose, hold through busy frame, retry on free frame
    daddr = 3'd5; tx_req = 1'b1;
    run_frame(1'b1, 3'd3, 1'b0);
    chk(lost == 1'b1, "R9 first attempt lost", int'(lost), 1);
    run_frame(1'b0, 3'd0, 1'b1);
    chk(lost == 1'b1 && granted == 1'b0, "R9 lost kept on busy frame", int'({granted, lost}), 1);
    run_frame(1'b0, 3'd0, 1'b0);
    chk(granted == 1'b1 && lost == 1'b0, "R9 retry wins", int'({granted, lost}), 2);
    tx_req = 1'b0;
    run_frame(1'b0, 3'd0, 1'b0);

    // R10: disabled
    arb_en = 1'b0; sw_req = 1'b1; daddr = 3'd0;
    run_frame(1'b0, 3'd0, 1'b0);
    chk(bad_pos == 0 && drv_addr == 3'b000 && bac_drv == 1'b0, "R10 drive while disabled",
        int'(drv_addr), 0);
    chk(granted == 1'b0, "R10 no grant while disabled", int'(granted), 0);
    arb_en = 1'b1;
    run_frame(1'b0, 3'd0, 1'b0);
    chk(granted == 1'b1, "R10 grant after enable", int'(granted), 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R11 actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule